// File: doc/BRIEF.md
# Endpoint Configuration-Ready Request Gate

This block stands between the transaction layer of a PCI Express endpoint and its Type 0 configuration header. It holds two pieces of local state: an identity register with the 16-bit subsystem ID and subsystem vendor ID, and a configuration-ready flag. Until local software raises the flag, every configuration read or write from the external host is answered with a Configuration Request Retry Status (CRS) completion and has no effect. This holds off host enumeration until the header is fully programmed. After the flag is set, requests are serviced and a read of header dword 0x2C returns the programmed identity.

Local software reaches both registers over a simple register bus. The write is synchronous and the read is combinational. Host requests arrive on an abstract valid/ready port that carries a dword address, write data and a tag. Each accepted request yields exactly one completion on a valid/ready port. While a completion waits to be taken, no new request is accepted. A mode input selects endpoint or root operation, and the identity register exists only in endpoint mode. A small writable command dword at header dword 1 makes the effect of writes observable.

Top module: `epcfg_gate`

## Requirements
- R1: A configuration request accepted while the ready flag is clear completes with status 3'b010 (retry) and data zero.
- R2: A configuration request accepted while the ready flag is set completes with status 3'b000 (successful). A write's completion carries data zero.
- R3: On reset the ready flag takes the value of the strap input `ready_strap`. Bits 31..1 of the ready register at local offset 0x4B0 always read zero.
- R4: Bit 0 of local offset 0x4B0 is the ready flag. A local write loads it from write-data bit 0, and a local read returns it.
- R5: In endpoint mode, local offset 0x478 is a read/write identity register that resets to zero. Bits 31..16 hold the subsystem ID and bits 15..0 hold the subsystem vendor ID.
- R6: A serviced read of header dword 11 (byte 0x2C) returns the identity register with the same bit arrangement. Serviced writes to that dword change nothing.
- R7: When `ep_mode` is 0 (root), local offset 0x478 reads zero, writes to it are ignored, and header dword 11 reads zero.
- R8: A write that receives a retry completion leaves every header register unchanged.
- R9: A request completes according to the ready flag as it stood before the clock edge that accepted it. A local write to the flag on that same edge does not affect that request.
- R10: Each completion carries the tag of its request and appears on the cycle after acceptance. It holds its tag, status and data until taken with `cpl_ready`. `req_ready` is low while a completion is pending.
- R11: Local reads of any offset other than 0x478 and 0x4B0 return zero, and local writes to them change no register.
- R12: Header dword 1 is a command register that resets to zero. A serviced write stores the write data ANDed with parameter `CMD_WMASK` (default 0x0000_0547), and a serviced read returns it. Every other header dword reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready_strap | input | 1 | Power-on strap giving the reset value of the ready flag |
| ep_mode | input | 1 | 1 = endpoint, 0 = root (identity register absent) |
| lb_addr | input | LB_AW | Local register-bus byte offset |
| lb_wen | input | 1 | Local register-bus write strobe |
| lb_wdata | input | 32 | Local register-bus write data |
| lb_rdata | output | 32 | Local register-bus read data (combinational) |
| req_valid | input | 1 | Inbound configuration request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = configuration write, 0 = read |
| req_dw | input | DW_AW | Header dword address |
| req_wdata | input | 32 | Configuration write data |
| req_tag | input | TAG_W | Requester tag |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion taken when high together with cpl_valid |
| cpl_status | output | 3 | Completion status: 000 successful, 010 retry |
| cpl_data | output | 32 | Completion read data |
| cpl_tag | output | TAG_W | Tag of the request being completed |

## Verification
Local-bus reads are combinational, so the bench sets the offset at a falling edge and samples read data 1 ns later. A local write takes effect at the next rising edge and is read back no earlier than the following falling edge. A completion is due one cycle after the accepting rising edge. The bench therefore samples it at the very next falling edge, which also checks that latency. The hold test withholds `cpl_ready` for several cycles and samples at each falling edge. The same-edge test drives the request and the flag write within one half-cycle, so the sampled flag is decided by a single rising edge.

// File: rtl/epcfg_pkg.sv
package epcfg_pkg;

    localparam int TAG_W = 8;

    // Local register-bus byte offsets
    localparam int OFF_IDENT = 'h478;
    localparam int OFF_READY = 'h4B0;

    // Header dword indices
    localparam int HDR_DW_CMD   = 1;
    localparam int HDR_DW_IDENT = 11;

    typedef enum logic [2:0] {
        CPL_SC  = 3'b000,
        CPL_UR  = 3'b001,
        CPL_CRS = 3'b010,
        CPL_CA  = 3'b100
    } cpl_stat_e;

    typedef struct packed {
        cpl_stat_e          status;
        logic [31:0]        data;
        logic [TAG_W-1:0]   tag;
    } cpl_t;

    function automatic logic [31:0] ident_word(input logic [15:0] sub_id,
                                               input logic [15:0] sub_vid);
        return {sub_id, sub_vid};
    endfunction

endpackage

// File: rtl/epcfg_lregs.sv
module epcfg_lregs
    import epcfg_pkg::*;
#(
    parameter int LB_AW = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ready_strap,
    input  logic             ep_mode,
    input  logic [LB_AW-1:0] lb_addr,
    input  logic             lb_wen,
    input  logic [31:0]      lb_wdata,
    output logic [31:0]      lb_rdata,
    output logic             cfg_rdy,
    output logic [31:0]      ident_vis
);
    localparam logic [LB_AW-1:0] A_IDENT = LB_AW'(OFF_IDENT);
    localparam logic [LB_AW-1:0] A_READY = LB_AW'(OFF_READY);

    logic [15:0] sub_id_q;
    logic [15:0] sub_vid_q;
    logic        rdy_q;
    logic        hit_ident;
    logic        hit_ready;

    assign hit_ident = ep_mode && (lb_addr == A_IDENT);
    assign hit_ready = (lb_addr == A_READY);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q     <= ready_strap;
            sub_id_q  <= '0;
            sub_vid_q <= '0;
        end else if (lb_wen) begin
            if (hit_ready) begin
                rdy_q <= lb_wdata[0];
            end
            if (hit_ident) begin
                sub_id_q  <= lb_wdata[31:16];
                sub_vid_q <= lb_wdata[15:0];
            end
        end
    end

    always_comb begin
        lb_rdata = '0;
        if (hit_ready) begin
            lb_rdata = {31'b0, rdy_q};
        end else if (hit_ident) begin
            lb_rdata = ident_word(sub_id_q, sub_vid_q);
        end
    end

    assign cfg_rdy   = rdy_q;
    assign ident_vis = ep_mode ? ident_word(sub_id_q, sub_vid_q) : 32'b0;
endmodule

// File: rtl/epcfg_hdr.sv
module epcfg_hdr
    import epcfg_pkg::*;
#(
    parameter int          DW_AW     = 10,
    parameter logic [31:0] CMD_WMASK = 32'h0000_0547
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DW_AW-1:0] dw,
    input  logic [31:0]      wdata,
    input  logic [31:0]      ident,
    output logic [31:0]      rdata,
    output logic [31:0]      cmd
);
    localparam logic [DW_AW-1:0] D_CMD   = DW_AW'(HDR_DW_CMD);
    localparam logic [DW_AW-1:0] D_IDENT = DW_AW'(HDR_DW_IDENT);

    logic [31:0] cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (wr_en && (dw == D_CMD)) begin
            cmd_q <= wdata & CMD_WMASK;
        end
    end

    always_comb begin
        unique case (dw)
            D_CMD:   rdata = cmd_q;
            D_IDENT: rdata = ident;
            default: rdata = '0;
        endcase
    end

    assign cmd = cmd_q;
endmodule

// File: rtl/epcfg_cpl.sv
module epcfg_cpl
    import epcfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cpl_t load_cpl,
    input  logic take,
    output logic pend,
    output cpl_t cur
);
    logic pend_q;
    cpl_t cpl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            cpl_q  <= '{status: CPL_SC, data: '0, tag: '0};
        end else if (load) begin
            pend_q <= 1'b1;
            cpl_q  <= load_cpl;
        end else if (take) begin
            pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;
    assign cur  = cpl_q;
endmodule

// File: rtl/epcfg_gate.sv
module epcfg_gate
    import epcfg_pkg::*;
#(
    parameter int          LB_AW     = 12,
    parameter int          DW_AW     = 10,
    parameter logic [31:0] CMD_WMASK = 32'h0000_0547
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ready_strap,
    input  logic             ep_mode,
    input  logic [LB_AW-1:0] lb_addr,
    input  logic             lb_wen,
    input  logic [31:0]      lb_wdata,
    output logic [31:0]      lb_rdata,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [DW_AW-1:0] req_dw,
    input  logic [31:0]      req_wdata,
    input  logic [TAG_W-1:0] req_tag,
    output logic             cpl_valid,
    input  logic             cpl_ready,
    output logic [2:0]       cpl_status,
    output logic [31:0]      cpl_data,
    output logic [TAG_W-1:0] cpl_tag
);
    logic        cfg_rdy;
    logic [31:0] ident_vis;
    logic [31:0] hdr_rdata;
    logic [31:0] hdr_cmd;
    logic        accept;
    logic        pend;
    cpl_t        next_cpl;
    cpl_t        cur_cpl;

    epcfg_lregs #(.LB_AW(LB_AW)) i_lregs (
        .clk        (clk),
        .rst        (rst),
        .ready_strap(ready_strap),
        .ep_mode    (ep_mode),
        .lb_addr    (lb_addr),
        .lb_wen     (lb_wen),
        .lb_wdata   (lb_wdata),
        .lb_rdata   (lb_rdata),
        .cfg_rdy    (cfg_rdy),
        .ident_vis  (ident_vis)
    );

    assign req_ready = !pend;
    assign accept    = req_valid && req_ready;

    epcfg_hdr #(.DW_AW(DW_AW), .CMD_WMASK(CMD_WMASK)) i_hdr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (accept && cfg_rdy && req_write),
        .dw    (req_dw),
        .wdata (req_wdata),
        .ident (ident_vis),
        .rdata (hdr_rdata),
        .cmd   (hdr_cmd)
    );

    always_comb begin
        next_cpl.tag = req_tag;
        if (cfg_rdy) begin
            next_cpl.status = CPL_SC;
            next_cpl.data   = req_write ? 32'b0 : hdr_rdata;
        end else begin
            next_cpl.status = CPL_CRS;
            next_cpl.data   = 32'b0;
        end
    end

    epcfg_cpl i_cpl (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_cpl (next_cpl),
        .take     (cpl_ready),
        .pend     (pend),
        .cur      (cur_cpl)
    );

    assign cpl_valid  = pend;
    assign cpl_status = cur_cpl.status;
    assign cpl_data   = cur_cpl.data;
    assign cpl_tag    = cur_cpl.tag;
endmodule

// File: rtl/epcfg_gate_chk.sv
module epcfg_gate_chk
    import epcfg_pkg::*;
#(
    parameter int LB_AW = 12,
    parameter int DW_AW = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             ready_strap,
    input logic             ep_mode,
    input logic [LB_AW-1:0] lb_addr,
    input logic [31:0]      lb_rdata,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic [TAG_W-1:0] req_tag,
    input logic             cpl_valid,
    input logic             cpl_ready,
    input logic [2:0]       cpl_status,
    input logic [31:0]      cpl_data,
    input logic [TAG_W-1:0] cpl_tag,
    input logic             cfg_rdy,
    input logic [31:0]      hdr_cmd
);
    logic acc;
    assign acc = req_valid && req_ready;

    p_crs_unready_r1: assert property (@(posedge clk) disable iff (rst)
        acc && !cfg_rdy |=> cpl_valid && cpl_status == 3'b010 && cpl_data == 32'b0);

    p_sc_ready_r2: assert property (@(posedge clk) disable iff (rst)
        acc && cfg_rdy |=> cpl_valid && cpl_status == 3'b000);

    p_strap_reset_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_rdy == $past(ready_strap));

    p_ready_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        lb_addr == LB_AW'(OFF_READY) |-> lb_rdata[31:1] == 31'b0);

    p_root_ident_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !ep_mode && lb_addr == LB_AW'(OFF_IDENT) |-> lb_rdata == 32'b0);

    p_retry_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        acc && !cfg_rdy && req_write |=> $stable(hdr_cmd));

    p_tag_echo_r10: assert property (@(posedge clk) disable iff (rst)
        acc |=> cpl_tag == $past(req_tag));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_tag)
                                    && $stable(cpl_status) && $stable(cpl_data));

    p_stall_r10: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> !req_ready);
endmodule

bind epcfg_gate epcfg_gate_chk #(.LB_AW(LB_AW), .DW_AW(DW_AW)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .ready_strap(ready_strap),
    .ep_mode    (ep_mode),
    .lb_addr    (lb_addr),
    .lb_rdata   (lb_rdata),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_tag    (req_tag),
    .cpl_valid  (cpl_valid),
    .cpl_ready  (cpl_ready),
    .cpl_status (cpl_status),
    .cpl_data   (cpl_data),
    .cpl_tag    (cpl_tag),
    .cfg_rdy    (cfg_rdy),
    .hdr_cmd    (hdr_cmd)
);

// File: tb/test_epcfg_gate.sv
`timescale 1ns/1ps
module test_epcfg_gate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ready_strap = 1'b0;
    logic        ep_mode = 1'b1;
    logic [11:0] lb_addr = '0;
    logic        lb_wen = 1'b0;
    logic [31:0] lb_wdata = '0;
    logic [31:0] lb_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [9:0]  req_dw = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  req_tag = '0;
    logic        cpl_valid;
    logic        cpl_ready = 1'b0;
    logic [2:0]  cpl_status;
    logic [31:0] cpl_data;
    logic [7:0]  cpl_tag;

    int checks = 0;
    int errors = 0;

    localparam logic [11:0] A_IDENT = 12'h478;
    localparam logic [11:0] A_READY = 12'h4B0;
    localparam logic [31:0] IDV     = 32'hA5C3_1E77;
    localparam logic [2:0]  SC  = 3'b000;
    localparam logic [2:0]  CRS = 3'b010;

    // {write, dw, wdata, tag, exp_status, exp_data}
    localparam int VW = 1 + 10 + 32 + 8 + 3 + 32;
    localparam logic [VW-1:0] VEC [8] = '{
        {1'b1, 10'd1,  32'hFFFF_FFFF, 8'h11, SC, 32'h0},
        {1'b0, 10'd1,  32'h0,         8'h12, SC, 32'h0000_0547},
        {1'b0, 10'd11, 32'h0,         8'h13, SC, IDV},
        {1'b1, 10'd11, 32'hDEAD_BEEF, 8'h14, SC, 32'h0},
        {1'b0, 10'd11, 32'h0,         8'h15, SC, IDV},
        {1'b0, 10'd0,  32'h0,         8'h16, SC, 32'h0},
        {1'b1, 10'd1,  32'h0000_0002, 8'h17, SC, 32'h0},
        {1'b0, 10'd1,  32'h0,         8'h18, SC, 32'h0000_0002}
    };

    epcfg_gate i_epcfg_gate (
        .clk(clk), .rst(rst), .ready_strap(ready_strap), .ep_mode(ep_mode),
        .lb_addr(lb_addr), .lb_wen(lb_wen), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_dw(req_dw), .req_wdata(req_wdata), .req_tag(req_tag),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_status(cpl_status),
        .cpl_data(cpl_data), .cpl_tag(cpl_tag)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        lb_addr = a; lb_wdata = d; lb_wen = 1'b1;
        @(negedge clk);
        lb_wen = 1'b0;
    endtask

    task automatic lb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        lb_addr = a;
        #1 d = lb_rdata;
    endtask

    task automatic cfg(input logic wr, input logic [9:0] dw, input logic [31:0] wd,
                       input logic [7:0] tg, output logic vld, output logic [2:0] st,
                       output logic [31:0] dt, output logic [7:0] tgo);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_dw = dw; req_wdata = wd; req_tag = tg;
        @(negedge clk);
        req_valid = 1'b0;
        vld = cpl_valid; st = cpl_status; dt = cpl_data; tgo = cpl_tag;
        cpl_ready = 1'b1;
        @(negedge clk);
        cpl_ready = 1'b0;
    endtask

    task automatic do_reset(input logic strap, input logic mode);
        @(negedge clk);
        rst = 1'b1; ready_strap = strap; ep_mode = mode;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic        v;
        logic [2:0]  s;
        logic [31:0] d;
        logic [7:0]  t;

        // ---- endpoint mode, strap clear ----
        do_reset(1'b0, 1'b1);
        #1;
        chk("R10 reset cpl_valid", {31'b0, cpl_valid}, 32'd0);
        chk("R10 reset req_ready", {31'b0, req_ready}, 32'd1);
        lb_rd(A_READY, d); chk("R3 ready resets to strap 0", d, 32'd0);
        lb_rd(A_IDENT, d); chk("R5 identity resets to zero", d, 32'd0);

        cfg(1'b0, 10'd11, 32'h0, 8'h41, v, s, d, t);
        chk("R1 retry read valid", {31'b0, v}, 32'd1);
        chk("R1 retry read status", {29'b0, s}, {29'b0, CRS});
        chk("R1 retry read data", d, 32'd0);
        chk("R10 retry read tag", {24'b0, t}, 32'h41);
        cfg(1'b1, 10'd1, 32'hFFFF_FFFF, 8'h42, v, s, d, t);
        chk("R1 retry write status", {29'b0, s}, {29'b0, CRS});

        lb_wr(A_IDENT, IDV);
        lb_rd(A_IDENT, d); chk("R5 identity readback", d, IDV);

        // R9: flag set on the same edge that accepts a request
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_dw = 10'd11; req_tag = 8'h51;
        lb_addr = A_READY; lb_wdata = 32'hFFFF_FFFF; lb_wen = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; lb_wen = 1'b0;
        chk("R9 set on accept edge still retries", {29'b0, cpl_status}, {29'b0, CRS});
        cpl_ready = 1'b1;
        @(negedge clk);
        cpl_ready = 1'b0;
        lb_rd(A_READY, d); chk("R4 ready readback one, R3 upper zero", d, 32'd1);

        cfg(1'b0, 10'd1, 32'h0, 8'h52, v, s, d, t);
        chk("R2 serviced status", {29'b0, s}, {29'b0, SC});
        chk("R8 retried write left command zero", d, 32'd0);

        // table of serviced requests
        for (int i = 0; i < 8; i++) begin
            cfg(VEC[i][85], VEC[i][84:75], VEC[i][74:43], VEC[i][42:35], v, s, d, t);
            chk($sformatf("R2 vec%0d status", i), {29'b0, s}, {29'b0, VEC[i][34:32]});
            chk($sformatf("R6/R12 vec%0d data", i), d, VEC[i][31:0]);
            chk($sformatf("R10 vec%0d tag", i), {24'b0, t}, {24'b0, VEC[i][42:35]});
        end

        // R9: flag cleared on the accepting edge still services
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_dw = 10'd11; req_tag = 8'h61;
        lb_addr = A_READY; lb_wdata = 32'h0; lb_wen = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; lb_wen = 1'b0;
        chk("R9 clear on accept edge still serviced", {29'b0, cpl_status}, {29'b0, SC});
        chk("R9 clear on accept edge data", cpl_data, IDV);
        cpl_ready = 1'b1;
        @(negedge clk);
        cpl_ready = 1'b0;
        cfg(1'b0, 10'd11, 32'h0, 8'h62, v, s, d, t);
        chk("R4 cleared flag retries again R1", {29'b0, s}, {29'b0, CRS});
        lb_rd(A_READY, d); chk("R4 ready readback zero", d, 32'd0);

        // R11: unimplemented offsets
        lb_wr(12'h47C, 32'h1234_5678);
        lb_wr(12'h4B4, 32'hFFFF_FFFF);
        lb_rd(12'h47C, d); chk("R11 unimplemented reads zero", d, 32'd0);
        lb_rd(A_IDENT, d); chk("R11 identity untouched", d, IDV);
        lb_rd(A_READY, d); chk("R11 ready untouched", d, 32'd0);

        // R10: hold while not taken
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_dw = 10'd3; req_tag = 8'h77;
        @(negedge clk);
        req_valid = 1'b1; req_tag = 8'h78;
        repeat (3) begin
            @(negedge clk);
            chk("R10 completion held", {31'b0, cpl_valid}, 32'd1);
            chk("R10 held tag", {24'b0, cpl_tag}, 32'h77);
            chk("R10 stalled", {31'b0, req_ready}, 32'd0);
        end
        req_valid = 1'b0;
        cpl_ready = 1'b1;
        @(negedge clk);
        cpl_ready = 1'b0;
        chk("R10 taken", {31'b0, cpl_valid}, 32'd0);

        // ---- root mode, strap set ----
        do_reset(1'b1, 1'b0);
        lb_rd(A_READY, d); chk("R3 ready resets to strap 1", d, 32'd1);
        cfg(1'b0, 10'd11, 32'h0, 8'h81, v, s, d, t);
        chk("R2 strap-ready serviced", {29'b0, s}, {29'b0, SC});
        chk("R7 root header ident zero", d, 32'd0);
        lb_wr(A_IDENT, IDV);
        lb_rd(A_IDENT, d); chk("R7 root identity reads zero", d, 32'd0);
        @(negedge clk);
        ep_mode = 1'b1;
        lb_rd(A_IDENT, d); chk("R7 root write was ignored", d, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule